// File: doc/BRIEF.md
# Descriptor Ring Position Counter

This block keeps track of which descriptor a DMA engine is working on inside a circular ring of descriptors. The ring size is stored as a negative two's-complement number (the length register). The position counter runs from that negative value upward. The first descriptor is the one whose count equals the length register, and the last descriptor is the one whose count is all ones (-1). Each advance strobe from the DMA engine moves the counter one step forward. An advance at -1 reloads the counter from the length register, so the position wraps back to the first descriptor.

Software can read and write both registers through a small register port, but only while the stop control is high. At any other time writes are dropped and reads return zero. An initialization strobe loads the length register from an external length value. The block also provides a zero-based descriptor index and a last-descriptor flag, both derived from the count and the length.

Top module: `ring_pos_tracker`

## Requirements
- R1: After reset both the counter and the length register hold all ones. As a result the index output is 0 and the last flag is 1.
- R2: While `stop_i` is 1, a write (`reg_wr_i`=1) loads `reg_wdata_i` into the counter when `reg_sel_i`=0, or into the length register when `reg_sel_i`=1. The new value is visible after the next clock edge.
- R3: A write while `stop_i` is 0 changes neither the counter nor the length register.
- R4: The read data is combinational. It equals the selected register (0 selects the counter, 1 selects the length) only when `reg_rd_i`=1 and `stop_i`=1. In every other case it is zero.
- R5: An advance strobe while the count is not all ones increments the count by one, modulo 2^CW.
- R6: An advance strobe while the count is all ones loads the counter with the length register value that was present before that clock edge, which is a wrap to the first descriptor.
- R7: `index_o` always equals the count minus the length register, modulo 2^CW.
- R8: `last_o` is 1 exactly when `count_o` is all ones.
- R9: `init_load_i` loads `init_len_i` into the length register and leaves the counter alone. If a software length write happens in the same cycle, the initialization load wins.
- R10: A software write to the length register leaves the counter unchanged. The new length first affects the count at the next wrap.
- R11: A software counter write in the same cycle as an advance strobe wins over the advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_i | input | 1 | Stop control; enables register access |
| reg_sel_i | input | 1 | Register select: 0 counter, 1 length |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | CW | Register write data |
| reg_rdata_o | output | CW | Register read data |
| adv_i | input | 1 | Advance to next descriptor |
| init_load_i | input | 1 | Load length register from `init_len_i` |
| init_len_i | input | CW | Two's-complement ring length for initialization |
| count_o | output | CW | Current position count |
| index_o | output | CW | Zero-based descriptor index |
| last_o | output | 1 | Count is at the last descriptor |

## Verification
The advance path is exercised on a four-entry ring, on a one-entry ring (length -1, where every advance is also a wrap), and on a longer ring whose length is changed part-way through. Together these separate increment-only behaviour from wrap behaviour and from the use of a stale length. Register writes and reads are driven with the stop control both high and low, which shows whether the access gate is applied to each path. Collision cycles are also driven: a counter write together with an advance, and an initialization load together with a length write. These show which source the design gives priority to. A stretch of random traffic is compared against the behavioural model on every cycle.

// File: rtl/ring_pos_pkg.sv
package ring_pos_pkg;
   typedef enum logic {
      SEL_COUNT  = 1'b0,
      SEL_LENGTH = 1'b1
   } ring_reg_sel_e;
endpackage

// File: rtl/ring_sw_port.sv
module ring_sw_port
   import ring_pos_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          stop_i,
   input  logic          sel_i,
   input  logic          wr_i,
   input  logic          rd_i,
   input  logic [CW-1:0] cnt_q_i,
   input  logic [CW-1:0] len_q_i,
   output logic          cnt_we_o,
   output logic          len_we_o,
   output logic [CW-1:0] rdata_o
);
   ring_reg_sel_e sel;
   logic          open_wr;
   logic          open_rd;

   assign sel     = ring_reg_sel_e'(sel_i);
   assign open_wr = stop_i & wr_i;
   assign open_rd = stop_i & rd_i;

   assign cnt_we_o = open_wr & (sel == SEL_COUNT);
   assign len_we_o = open_wr & (sel == SEL_LENGTH);

   always_comb begin
      rdata_o = '0;
      if (open_rd) begin
         unique case (sel)
            SEL_COUNT:  rdata_o = cnt_q_i;
            SEL_LENGTH: rdata_o = len_q_i;
            default:    rdata_o = '0;
         endcase
      end
   end
endmodule

// File: rtl/ring_len_reg.sv
module ring_len_reg #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init_load_i,
   input  logic [CW-1:0] init_len_i,
   input  logic          sw_we_i,
   input  logic [CW-1:0] sw_wdata_i,
   output logic [CW-1:0] len_q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q_o <= '1;
      end else if (init_load_i) begin
         len_q_o <= init_len_i;
      end else if (sw_we_i) begin
         len_q_o <= sw_wdata_i;
      end
   end
endmodule

// File: rtl/ring_pos_counter.sv
module ring_pos_counter #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv_i,
   input  logic          sw_we_i,
   input  logic [CW-1:0] sw_wdata_i,
   input  logic [CW-1:0] len_q_i,
   output logic [CW-1:0] cnt_q_o,
   output logic          at_last_o
);
   localparam logic [CW-1:0] LAST_POS = '1;
   localparam logic [CW-1:0] ONE      = CW'(1);

   logic [CW-1:0] step_val;

   assign at_last_o = (cnt_q_o == LAST_POS);
   assign step_val  = at_last_o ? len_q_i : (cnt_q_o + ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q_o <= LAST_POS;
      end else if (sw_we_i) begin
         cnt_q_o <= sw_wdata_i;
      end else if (adv_i) begin
         cnt_q_o <= step_val;
      end
   end
endmodule

// File: rtl/ring_pos_tracker.sv
module ring_pos_tracker #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stop_i,
   input  logic          reg_sel_i,
   input  logic          reg_wr_i,
   input  logic          reg_rd_i,
   input  logic [CW-1:0] reg_wdata_i,
   output logic [CW-1:0] reg_rdata_o,
   input  logic          adv_i,
   input  logic          init_load_i,
   input  logic [CW-1:0] init_len_i,
   output logic [CW-1:0] count_o,
   output logic [CW-1:0] index_o,
   output logic          last_o
);
   generate
      if (CW < 2) begin : g_bad_width
         $error("ring_pos_tracker: CW must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] len_q;
   logic          cnt_we;
   logic          len_we;

   ring_sw_port #(.CW(CW)) u_port (
      .stop_i   (stop_i),
      .sel_i    (reg_sel_i),
      .wr_i     (reg_wr_i),
      .rd_i     (reg_rd_i),
      .cnt_q_i  (cnt_q),
      .len_q_i  (len_q),
      .cnt_we_o (cnt_we),
      .len_we_o (len_we),
      .rdata_o  (reg_rdata_o)
   );

   ring_len_reg #(.CW(CW)) u_len (
      .clk         (clk),
      .rst_n       (rst_n),
      .init_load_i (init_load_i),
      .init_len_i  (init_len_i),
      .sw_we_i     (len_we),
      .sw_wdata_i  (reg_wdata_i),
      .len_q_o     (len_q)
   );

   ring_pos_counter #(.CW(CW)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv_i      (adv_i),
      .sw_we_i    (cnt_we),
      .sw_wdata_i (reg_wdata_i),
      .len_q_i    (len_q),
      .cnt_q_o    (cnt_q),
      .at_last_o  (last_o)
   );

   assign count_o = cnt_q;
   assign index_o = cnt_q - len_q;
endmodule

// File: rtl/ring_pos_tracker_chk.sv
module ring_pos_tracker_chk #(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          stop_i,
   input logic          reg_sel_i,
   input logic          reg_wr_i,
   input logic          reg_rd_i,
   input logic [CW-1:0] reg_wdata_i,
   input logic [CW-1:0] reg_rdata_o,
   input logic          adv_i,
   input logic          init_load_i,
   input logic [CW-1:0] init_len_i,
   input logic [CW-1:0] count_o,
   input logic [CW-1:0] index_o,
   input logic          last_o
);
   logic cnt_wr;
   logic len_wr;
   assign cnt_wr = stop_i && reg_wr_i && !reg_sel_i;
   assign len_wr = stop_i && reg_wr_i && reg_sel_i;

   // R5: plain step
   p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i && !cnt_wr && (count_o != '1) |=> count_o == $past(count_o) + CW'(1));

   // R6: wrap lands on the first descriptor (index zero)
   p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i && !cnt_wr && !len_wr && !init_load_i && (count_o == '1) |=> index_o == '0);

   // R3: closed port leaves state alone
   p_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_i && !adv_i && !init_load_i |=> $stable(count_o) && $stable(index_o));

   // R4: read data zero without an open read
   p_rdzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(stop_i && reg_rd_i) |-> reg_rdata_o == '0);

   // R8: flag tracks all-ones count
   p_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
      last_o == (count_o == '1));

   // R11: counter write beats advance
   p_cntwr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> count_o == $past(reg_wdata_i));
endmodule

bind ring_pos_tracker ring_pos_tracker_chk #(.CW(CW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .stop_i      (stop_i),
   .reg_sel_i   (reg_sel_i),
   .reg_wr_i    (reg_wr_i),
   .reg_rd_i    (reg_rd_i),
   .reg_wdata_i (reg_wdata_i),
   .reg_rdata_o (reg_rdata_o),
   .adv_i       (adv_i),
   .init_load_i (init_load_i),
   .init_len_i  (init_len_i),
   .count_o     (count_o),
   .index_o     (index_o),
   .last_o      (last_o)
);

// File: tb/test_ring_pos_tracker.sv
`timescale 1ns/1ps
module test_ring_pos_tracker;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          stop_i = 1'b0;
   logic          reg_sel_i = 1'b0;
   logic          reg_wr_i = 1'b0;
   logic          reg_rd_i = 1'b0;
   logic [CW-1:0] reg_wdata_i = '0;
   logic [CW-1:0] reg_rdata_o;
   logic          adv_i = 1'b0;
   logic          init_load_i = 1'b0;
   logic [CW-1:0] init_len_i = '0;
   logic [CW-1:0] count_o;
   logic [CW-1:0] index_o;
   logic          last_o;

   int    n_tests = 0;
   int    n_fail  = 0;
   int    cycles  = 0;
   bit    done    = 0;
   string tag     = "R1";

   // behavioural reference
   int unsigned m_cnt = 32'hFFFF;
   int unsigned m_len = 32'hFFFF;

   always #2.5 clk = ~clk;

   ring_pos_tracker #(.CW(CW)) i_ring_pos_tracker (.*);

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 32'hFFFF;
         m_len = 32'hFFFF;
      end else begin
         int unsigned nc, nl;
         nc = m_cnt;
         nl = m_len;
         if (stop_i && reg_wr_i && !reg_sel_i)  nc = reg_wdata_i;
         else if (adv_i)                        nc = (m_cnt == 32'hFFFF) ? m_len : (m_cnt + 1) % 65536;
         if (init_load_i)                       nl = init_len_i;
         else if (stop_i && reg_wr_i && reg_sel_i) nl = reg_wdata_i;
         m_cnt = nc;
         m_len = nl;
      end
   end

   task automatic chk(input string what, input int unsigned act, input int unsigned exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic compare();
      int unsigned e_rd;
      e_rd = (stop_i && reg_rd_i) ? (reg_sel_i ? m_len : m_cnt) : 0;
      chk("count", count_o, m_cnt);
      chk("index", index_o, (m_cnt - m_len) % 65536);
      chk("last", last_o, (m_cnt == 32'hFFFF) ? 1 : 0);
      chk("rdata", reg_rdata_o, e_rd);
   endtask

   // one cycle: check current state at the falling edge, then apply new inputs
   task automatic cyc(input bit stp, input bit sel, input bit wr, input bit rd,
                      input logic [CW-1:0] wd, input bit adv,
                      input bit ild, input logic [CW-1:0] ilen);
      @(negedge clk);
      compare();
      stop_i = stp; reg_sel_i = sel; reg_wr_i = wr; reg_rd_i = rd;
      reg_wdata_i = wd; adv_i = adv; init_load_i = ild; init_len_i = ilen;
   endtask

   task automatic idle(input bit stp);
      cyc(stp, 0, 0, 0, '0, 0, 0, '0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tag = "R1";
      idle(0);
      // explicit reset-state checks
      @(negedge clk);
      chk("R1 reset count", count_o, 16'hFFFF);
      chk("R1 reset index", index_o, 0);
      chk("R1 reset last", last_o, 1);

      tag = "R2";
      cyc(1, 1, 1, 0, 16'hFFFC, 0, 0, '0);   // length = -4
      cyc(1, 0, 1, 0, 16'hFFFC, 0, 0, '0);   // count at first descriptor
      tag = "R4";
      cyc(1, 0, 0, 1, '0, 0, 0, '0);
      cyc(1, 1, 0, 1, '0, 0, 0, '0);
      cyc(0, 1, 0, 1, '0, 0, 0, '0);          // read while stopped low
      cyc(1, 0, 0, 0, '0, 0, 0, '0);          // read strobe low
      tag = "R5 R6 R7 R8";
      for (int i = 0; i < 9; i++) cyc(0, 0, 0, 0, '0, 1, 0, '0);
      idle(0);

      tag = "R3";
      cyc(0, 0, 1, 0, 16'h1234, 0, 0, '0);
      cyc(0, 1, 1, 0, 16'h5678, 0, 0, '0);
      idle(0);
      cyc(1, 1, 0, 1, '0, 0, 0, '0);
      cyc(1, 0, 0, 1, '0, 0, 0, '0);

      tag = "R10";
      cyc(1, 1, 1, 0, 16'hFFF0, 0, 0, '0);   // length -16, counter untouched
      idle(1);
      for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0, '0, 1, 0, '0);
      idle(0);

      tag = "R9";
      cyc(1, 1, 1, 0, 16'h1234, 0, 1, 16'hFFF8);
      cyc(0, 0, 0, 0, '0, 0, 1, 16'hFFFA);
      cyc(1, 1, 0, 1, '0, 0, 0, '0);
      @(negedge clk);
      chk("R9 length after init", reg_rdata_o, 16'hFFFA);
      compare();
      idle(0);

      tag = "R11";
      cyc(1, 0, 1, 0, 16'hFFFF, 1, 0, '0);
      cyc(1, 0, 1, 0, 16'h0005, 1, 0, '0);
      idle(1);
      @(negedge clk);
      chk("R11 write wins", count_o, 16'h0005);
      compare();

      tag = "R6";
      cyc(1, 1, 1, 0, 16'hFFFF, 0, 0, '0);   // one-descriptor ring
      cyc(1, 0, 1, 0, 16'hFFFF, 0, 0, '0);
      for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, '0, 1, 0, '0);
      idle(0);

      tag = "R2 R3 R4 R5 R6 R7 R8 R9";
      for (int i = 0; i < 400; i++) begin
         logic [CW-1:0] wd;
         wd = ($urandom_range(0, 3) == 0) ? 16'hFFFF - 16'($urandom_range(0, 3)) : 16'hFFF0 | 16'($urandom_range(0, 15));
         cyc($urandom_range(0, 1), $urandom_range(0, 1), ($urandom_range(0, 5) == 0),
             $urandom_range(0, 1), wd, $urandom_range(0, 1),
             ($urandom_range(0, 15) == 0), 16'hFFF0 | 16'($urandom_range(0, 15)));
      end
      idle(0);
      idle(0);

      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule